// File: doc/BRIEF.md
# Output Protection and Power-Good Supervisor

This block guards the output of a step-down converter. Each clock it compares digitized output voltage, output current and controller temperature with limits. The voltage limits are computed from the programmed setpoint code. From those comparisons it drives three outputs:

- a power-stage enable;
- an open-drain style fault request for a status line shared by several converters;
- a power-good flag.

An overvoltage shuts the stage down and stays latched. Undervoltage and overcurrent start a hiccup: the stage is held off for a fixed retry period and then tries again. Overtemperature holds the stage off until the temperature has fallen to a lower release level.

Every protection condition must be seen on a run of consecutive clock edges before it acts, so single-sample noise is rejected. Power-good changes state under the same rule. It is also forced low while the output ramps or the stage is off. The enable pin polarity is chosen by a second pin. A low seen on the shared status line also turns the stage off, which lets one converter's fault stop its neighbours. The ADCs, ramp generator and power stage lie outside the block.

Top module: `outp_guard`

## Requirements
- R1: With `pol_pin` = 1 the enable is active when `en_pin` = 1. With `pol_pin` = 0 it is active when `en_pin` = 0. If the enable is active, `ok_in` = 1 and no fault is held, `pwr_en` is 1 after the next clock edge. If the enable is inactive, `pwr_en` is 0 after the next edge.
- R2: Overvoltage: `v_code` > max(floor(sp*13/10), OV_FLOOR) on QUAL_CYC consecutive edges latches a fault on the last of those edges. The latch stays set, whatever `v_code` does afterwards, until an edge samples the enable inactive.
- R3: Undervoltage: while `pwr_en` = 1 and `ramp` = 0, `v_code` < floor(sp*3/4) on QUAL_CYC consecutive edges starts a hiccup. `pwr_en` is 0 for exactly RETRY_CYC edges and then returns to 1. No undervoltage is detected while `ramp` = 1.
- R4: Overcurrent: `i_code` > floor(RATED_I*14/10) on QUAL_CYC consecutive edges starts the same hiccup as R3. A value equal to the limit does not trip.
- R5: Overtemperature: `t_code` >= OT_TRIP on QUAL_CYC consecutive edges holds the stage off. The hold is released on the first edge that sees `t_code` <= OT_CLEAR.
- R6: A protection condition that goes away before QUAL_CYC consecutive edges have seen it restarts its count and causes no trip.
- R7: `ok_low` is 1 exactly while a fault (R2, R3, R4, R5) is held. It changes on the same edge as the `pwr_en` drop that the fault causes, and `pwr_en` is never 1 while `ok_low` is 1.
- R8: `ok_in` = 0 sampled on an edge makes `pwr_en` 0 after that edge, without setting `ok_low`. The stage restarts on the first edge that sees `ok_in` = 1.
- R9: Power-good target: floor(sp*9/10) <= `v_code` <= floor(sp*11/10), `pwr_en` = 1, `ramp` = 0 and no fault held. `pg` takes a new target value once the value has differed from `pg` on QUAL_CYC consecutive edges.
- R10: `pg` is 0 after any edge that samples `ramp` = 1 or `pwr_en` = 0.
- R11: While `rst_n` = 0, `pwr_en`, `ok_low` and `pg` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp_code | input | VW | Programmed output voltage setpoint code |
| v_code | input | VW | Measured output voltage code |
| i_code | input | IW | Measured output current code |
| t_code | input | TW | Measured temperature code |
| en_pin | input | 1 | Enable pin level |
| pol_pin | input | 1 | Enable polarity: 1 active high, 0 active low |
| ramp | input | 1 | Output is ramping up or down |
| ok_in | input | 1 | Sampled level of the shared status line |
| pwr_en | output | 1 | Power-stage enable |
| ok_low | output | 1 | Request to pull the shared status line low |
| pg | output | 1 | Power-good flag |

## Verification
Any change of `pwr_en` or `ok_low` is due on the same edge that samples its cause. For a protection condition, that is the QUAL_CYC-th consecutive edge of the run. A hiccup returns the stage to on exactly RETRY_CYC edges after the trip. `pg` changes on the QUAL_CYC-th edge of a steady difference from its target, or one edge after ramping or power-off is seen.

The bench changes inputs only on falling edges. On each rising edge it advances a per-cycle model of these rules, and 1 ns after the edge it compares all three outputs. Directed runs sit exactly at these cycle counts, including one cycle short and one cycle late. A seeded random phase covers mixed inputs.

// File: rtl/og_pkg.sv
`timescale 1ns/1ps
package og_pkg;

   typedef enum logic [1:0] {
      FLT_OV = 2'd0,
      FLT_UV = 2'd1,
      FLT_OC = 2'd2,
      FLT_OT = 2'd3
   } flt_e;

   localparam int NFLT = 4;

   function automatic logic en_active(input logic pin, input logic pol);
      return pol ? pin : ~pin;
   endfunction

endpackage

// File: rtl/og_limits.sv
`timescale 1ns/1ps
module og_limits #(
   parameter int VW       = 10,
   parameter int OV_FLOOR = 200,
   localparam int XW      = VW + 4
) (
   input  logic [VW-1:0] sp,
   output logic [XW-1:0] ov_th,
   output logic [XW-1:0] uv_th,
   output logic [XW-1:0] pg_lo,
   output logic [XW-1:0] pg_hi
);

   localparam logic [XW-1:0] K3   = XW'(3);
   localparam logic [XW-1:0] K9   = XW'(9);
   localparam logic [XW-1:0] K10  = XW'(10);
   localparam logic [XW-1:0] K11  = XW'(11);
   localparam logic [XW-1:0] K13  = XW'(13);
   localparam logic [XW-1:0] FLR  = XW'(OV_FLOOR);

   logic [XW-1:0] spx;
   logic [XW-1:0] ov_raw;

   assign spx    = XW'(sp);
   assign ov_raw = (spx * K13) / K10;
   assign uv_th  = (spx * K3) >> 2;
   assign pg_lo  = (spx * K9) / K10;
   assign pg_hi  = (spx * K11) / K10;

   generate
      if (OV_FLOOR > 0) begin : g_floor
         assign ov_th = (ov_raw < FLR) ? FLR : ov_raw;
      end else begin : g_nofloor
         assign ov_th = ov_raw;
      end
   endgenerate

   always_comb begin
      assert (ov_th >= ov_raw) else $error("overvoltage limit below 130 percent"); // R2
   end

endmodule

// File: rtl/og_qual.sv
`timescale 1ns/1ps
module og_qual #(
   parameter int QUAL_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cond,
   output logic hit
);

   generate
      if (QUAL_CYC == 1) begin : g_direct
         assign hit = cond;
      end else begin : g_count
         localparam int CW = $clog2(QUAL_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);
         localparam logic [CW-1:0] TOP  = CW'(QUAL_CYC);

         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!cond) begin
               cnt <= '0;
            end else if (cnt != TOP) begin
               cnt <= cnt + 1'b1;
            end
         end

         assign hit = cond && (cnt >= LAST);

         AST_QUAL_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
            hit |-> (cond && $past(cond))); // R6
      end
   endgenerate

endmodule

// File: rtl/og_pgood.sv
`timescale 1ns/1ps
module og_pgood #(
   parameter int QUAL_CYC = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic target,
   input  logic force_low,
   output logic pg
);

   generate
      if (QUAL_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         pg <= 1'b0;
            else if (force_low) pg <= 1'b0;
            else                pg <= target;
         end
      end else begin : g_count
         localparam int CW = $clog2(QUAL_CYC + 1);
         localparam logic [CW-1:0] LAST = CW'(QUAL_CYC - 1);

         logic [CW-1:0] cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pg  <= 1'b0;
               cnt <= '0;
            end else if (force_low) begin
               pg  <= 1'b0;
               cnt <= '0;
            end else if (target == pg) begin
               cnt <= '0;
            end else if (cnt >= LAST) begin
               pg  <= target;
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   endgenerate

   AST_PG_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
      force_low |=> !pg); // R10

endmodule

// File: rtl/outp_guard.sv
`timescale 1ns/1ps
module outp_guard
   import og_pkg::*;
#(
   parameter int VW        = 10,
   parameter int IW        = 10,
   parameter int TW        = 8,
   parameter int QUAL_CYC  = 1200,
   parameter int RETRY_CYC = 26000000,
   parameter int OV_FLOOR  = 200,
   parameter int RATED_I   = 400,
   parameter int OT_TRIP   = 120,
   parameter int OT_CLEAR  = 110
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [VW-1:0] sp_code,
   input  logic [VW-1:0] v_code,
   input  logic [IW-1:0] i_code,
   input  logic [TW-1:0] t_code,
   input  logic          en_pin,
   input  logic          pol_pin,
   input  logic          ramp,
   input  logic          ok_in,
   output logic          pwr_en,
   output logic          ok_low,
   output logic          pg
);

   localparam int XW = VW + 4;
   localparam int RW = $clog2(RETRY_CYC + 1);
   localparam int OC_LIM = (RATED_I * 14) / 10;
   localparam logic [IW-1:0] OC_LIM_C = IW'(OC_LIM);
   localparam logic [TW-1:0] OT_SET_C = TW'(OT_TRIP);
   localparam logic [TW-1:0] OT_REL_C = TW'(OT_CLEAR);
   localparam logic [RW-1:0] RETRY_C  = RW'(RETRY_CYC);

   initial begin
      assert (QUAL_CYC >= 1)          else $error("QUAL_CYC must be at least 1");
      assert (RETRY_CYC >= 1)         else $error("RETRY_CYC must be at least 1");
      assert (OT_CLEAR < OT_TRIP)     else $error("release temperature must be below trip");
      assert (OT_TRIP < (1 << TW))    else $error("OT_TRIP does not fit TW");
      assert (OC_LIM < (1 << IW))     else $error("current limit does not fit IW");
      assert (OV_FLOOR < (1 << XW))   else $error("OV_FLOOR does not fit");
   end

   logic [XW-1:0] ov_th, uv_th, pg_lo, pg_hi;
   logic [XW-1:0] v_x;
   logic          en_act;
   logic [NFLT-1:0] cond, hit;

   logic          ov_lat, ot_lat;
   logic [RW-1:0] retry;
   logic          ov_n, ot_n, fault_n, fault_q, pwr_n;
   logic [RW-1:0] retry_n;
   logic          in_win, pg_target, pg_force;

   og_limits #(.VW(VW), .OV_FLOOR(OV_FLOOR)) u_lim (
      .sp   (sp_code),
      .ov_th(ov_th),
      .uv_th(uv_th),
      .pg_lo(pg_lo),
      .pg_hi(pg_hi)
   );

   assign v_x    = XW'(v_code);
   assign en_act = en_active(en_pin, pol_pin);

   always_comb begin
      cond         = '0;
      cond[FLT_OV] = v_x > ov_th;
      cond[FLT_UV] = pwr_en && !ramp && (v_x < uv_th);
      cond[FLT_OC] = i_code > OC_LIM_C;
      cond[FLT_OT] = t_code >= OT_SET_C;
   end

   generate
      for (genvar g = 0; g < NFLT; g++) begin : g_qual
         og_qual #(.QUAL_CYC(QUAL_CYC)) u_q (
            .clk  (clk),
            .rst_n(rst_n),
            .cond (cond[g]),
            .hit  (hit[g])
         );
      end
   endgenerate

   always_comb begin
      ov_n = hit[FLT_OV] | (ov_lat & en_act);
      ot_n = hit[FLT_OT] | (ot_lat & (t_code > OT_REL_C));
      if (hit[FLT_UV] || hit[FLT_OC])
         retry_n = RETRY_C;
      else if (retry != '0)
         retry_n = retry - 1'b1;
      else
         retry_n = '0;
      fault_n = ov_n | ot_n | (retry_n != '0);
      pwr_n   = en_act & ok_in & ~fault_n;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ov_lat <= 1'b0;
         ot_lat <= 1'b0;
         retry  <= '0;
         pwr_en <= 1'b0;
         ok_low <= 1'b0;
      end else begin
         ov_lat <= ov_n;
         ot_lat <= ot_n;
         retry  <= retry_n;
         pwr_en <= pwr_n;
         ok_low <= fault_n;
      end
   end

   assign fault_q   = ov_lat | ot_lat | (retry != '0);
   assign in_win    = (v_x >= pg_lo) && (v_x <= pg_hi);
   assign pg_target = in_win & pwr_en & ~ramp & ~fault_q;
   assign pg_force  = ~pwr_en | ramp;

   og_pgood #(.QUAL_CYC(QUAL_CYC)) u_pg (
      .clk      (clk),
      .rst_n    (rst_n),
      .target   (pg_target),
      .force_low(pg_force),
      .pg       (pg)
   );

   AST_EN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en_act |=> !pwr_en); // R1
   AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ov_lat && en_act) |=> !pwr_en); // R2
   AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ot_lat && (t_code > OT_REL_C)) |=> !pwr_en); // R5
   AST_OK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      ok_low |-> !pwr_en); // R7
   AST_EXT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !ok_in |=> !pwr_en); // R8
   AST_PG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |=> !pg); // R10

endmodule

// File: tb/test_outp_guard.sv
`timescale 1ns/1ps
module test_outp_guard;

   localparam int VW = 10, IW = 10, TW = 8;
   localparam int DLY = 4, RETRY = 30;
   localparam int OVF = 200, RATED = 400, OTT = 120, OTC = 110;
   localparam int OCL = (RATED * 14) / 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [VW-1:0] sp = '0, vv = '0;
   logic [IW-1:0] ii = '0;
   logic [TW-1:0] tt = '0;
   logic en = 1'b0, pol = 1'b1, ramp = 1'b0, okin = 1'b1;
   logic pwr_en, ok_low, pg;

   always #2.5 clk = ~clk;

   outp_guard #(
      .VW(VW), .IW(IW), .TW(TW), .QUAL_CYC(DLY), .RETRY_CYC(RETRY),
      .OV_FLOOR(OVF), .RATED_I(RATED), .OT_TRIP(OTT), .OT_CLEAR(OTC)
   ) i_outp_guard (
      .clk(clk), .rst_n(rst_n), .sp_code(sp), .v_code(vv), .i_code(ii),
      .t_code(tt), .en_pin(en), .pol_pin(pol), .ramp(ramp), .ok_in(okin),
      .pwr_en(pwr_en), .ok_low(ok_low), .pg(pg)
   );

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   // reference state
   int m_q[4];
   int m_rt = 0, m_pgc = 0;
   bit m_ov = 0, m_ot = 0, m_pwr = 0, m_okl = 0, m_pg = 0;

   function automatic int f_ov(input int s);
      int r = (s * 13) / 10;
      return (r < OVF) ? OVF : r;
   endfunction
   function automatic int f_uv(input int s);   return (s * 3) / 4;  endfunction
   function automatic int f_pglo(input int s); return (s * 9) / 10; endfunction
   function automatic int f_pghi(input int s); return (s * 11) / 10; endfunction

   task automatic chk(input bit good, input string tag, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic model_step();
      bit ea, fnow, pgt, frc, ovn, otn, fn, inw;
      bit c[4];
      bit h[4];
      int rn;
      ea = pol ? en : !en;
      c[0] = int'(vv) > f_ov(int'(sp));
      c[1] = m_pwr && !ramp && (int'(vv) < f_uv(int'(sp)));
      c[2] = int'(ii) > OCL;
      c[3] = int'(tt) >= OTT;
      for (int k = 0; k < 4; k++) begin
         h[k]   = c[k] && (m_q[k] >= DLY - 1);
         m_q[k] = c[k] ? ((m_q[k] >= DLY) ? DLY : m_q[k] + 1) : 0;
      end
      fnow = m_ov || m_ot || (m_rt != 0);
      inw  = (int'(vv) >= f_pglo(int'(sp))) && (int'(vv) <= f_pghi(int'(sp)));
      pgt  = inw && m_pwr && !ramp && !fnow;
      frc  = !m_pwr || ramp;
      if (frc) begin m_pg = 0; m_pgc = 0; end
      else if (pgt == m_pg) m_pgc = 0;
      else if (m_pgc >= DLY - 1) begin m_pg = pgt; m_pgc = 0; end
      else m_pgc++;
      ovn = h[0] || (m_ov && ea);
      otn = h[3] || (m_ot && (int'(tt) > OTC));
      rn  = (h[1] || h[2]) ? RETRY : ((m_rt > 0) ? m_rt - 1 : 0);
      fn  = ovn || otn || (rn != 0);
      m_ov = ovn; m_ot = otn; m_rt = rn;
      m_pwr = ea && okin && !fn;
      m_okl = fn;
   endtask

   task automatic step(input string tag);
      @(posedge clk);
      model_step();
      #1;
      chk(pwr_en == m_pwr, tag, "pwr_en", int'(pwr_en), int'(m_pwr));
      chk(ok_low == m_okl, tag, "ok_low", int'(ok_low), int'(m_okl));
      chk(pg == m_pg,      tag, "pg",     int'(pg),     int'(m_pg));
      @(negedge clk);
   endtask

   task automatic run(input int n, input string tag);
      for (int k = 0; k < n; k++) step(tag);
   endtask

   task automatic nominal();
      sp = 10'd400; vv = 10'd400; ii = 10'd100; tt = 8'd50;
      en = 1'b1; pol = 1'b1; ramp = 1'b0; okin = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      int unsigned seed;
      int seg, pct;
      seed = $urandom(32'h5eed_0042);
      for (int k = 0; k < 4; k++) m_q[k] = 0;
      nominal();
      repeat (3) @(negedge clk);
      // R11 reset state
      chk(pwr_en == 0, "R11", "pwr_en", int'(pwr_en), 0);
      chk(ok_low == 0, "R11", "ok_low", int'(ok_low), 0);
      chk(pg == 0,     "R11", "pg",     int'(pg), 0);
      rst_n = 1'b1;

      // R1 polarity
      run(2, "R1");
      chk(pwr_en == 1, "R1", "pwr_en active high", int'(pwr_en), 1);
      pol = 1'b0; run(1, "R1");
      chk(pwr_en == 0, "R1", "pwr_en low polarity en=1", int'(pwr_en), 0);
      en = 1'b0; run(1, "R1");
      chk(pwr_en == 1, "R1", "pwr_en low polarity en=0", int'(pwr_en), 1);
      pol = 1'b1; en = 1'b1; run(1, "R1");

      // R9 power-good rises
      run(DLY + 2, "R9");
      chk(pg == 1, "R9", "pg in window", int'(pg), 1);

      // R6 interrupted overvoltage
      vv = 10'd600; run(DLY - 1, "R6");
      vv = 10'd400; run(2, "R6");
      chk(pwr_en == 1, "R6", "no trip on short run", int'(pwr_en), 1);

      // R2 overvoltage latch
      vv = 10'd600; run(DLY, "R2");
      chk(pwr_en == 0, "R2", "ov trip", int'(pwr_en), 0);
      chk(ok_low == 1, "R7", "ok_low on ov", int'(ok_low), 1);
      vv = 10'd400; run(10, "R2");
      chk(pwr_en == 0, "R2", "ov stays latched", int'(pwr_en), 0);
      en = 1'b0; run(1, "R2");
      en = 1'b1; run(2, "R2");
      chk(pwr_en == 1, "R2", "ov cleared by enable", int'(pwr_en), 1);

      // R2 floor: sp=100 gives 130, floor 200 applies
      sp = 10'd100; vv = 10'd190; run(DLY + 2, "R2");
      chk(pwr_en == 1, "R2", "below floor", int'(pwr_en), 1);
      vv = 10'd210; run(DLY, "R2");
      chk(pwr_en == 0, "R2", "above floor", int'(pwr_en), 0);
      nominal(); en = 1'b0; run(1, "R2"); en = 1'b1; run(2, "R2");

      // R3 undervoltage hiccup timing
      vv = 10'd250; run(DLY, "R3");
      chk(pwr_en == 0, "R3", "uv trip", int'(pwr_en), 0);
      vv = 10'd400; run(RETRY - 1, "R3");
      chk(pwr_en == 0, "R3", "still retrying", int'(pwr_en), 0);
      run(1, "R3");
      chk(pwr_en == 1, "R3", "restart after retry", int'(pwr_en), 1);
      ramp = 1'b1; vv = 10'd250; run(DLY + 2, "R3");
      chk(pwr_en == 1, "R3", "uv ignored while ramping", int'(pwr_en), 1);
      chk(pg == 0, "R10", "pg low while ramping", int'(pg), 0);
      ramp = 1'b0; vv = 10'd400; run(1, "R3");

      // R4 overcurrent
      ii = IW'(OCL); run(DLY + 2, "R4");
      chk(pwr_en == 1, "R4", "at limit no trip", int'(pwr_en), 1);
      ii = IW'(OCL + 1); run(DLY, "R4");
      chk(pwr_en == 0, "R4", "oc trip", int'(pwr_en), 0);
      ii = 10'd100; run(RETRY, "R4");
      chk(pwr_en == 1, "R4", "oc restart", int'(pwr_en), 1);

      // R5 overtemperature hysteresis
      tt = 8'(OTT - 1); run(DLY + 2, "R5");
      chk(pwr_en == 1, "R5", "below trip", int'(pwr_en), 1);
      tt = 8'(OTT); run(DLY, "R5");
      chk(pwr_en == 0, "R5", "ot trip", int'(pwr_en), 0);
      tt = 8'(OTC + 1); run(5, "R5");
      chk(pwr_en == 0, "R5", "held above release", int'(pwr_en), 0);
      tt = 8'(OTC); run(1, "R5");
      chk(pwr_en == 1, "R5", "released", int'(pwr_en), 1);
      tt = 8'd50;

      // R8 external status low
      okin = 1'b0; run(1, "R8");
      chk(pwr_en == 0, "R8", "external off", int'(pwr_en), 0);
      chk(ok_low == 0, "R8", "no own fault", int'(ok_low), 0);
      okin = 1'b1; run(1, "R8");
      chk(pwr_en == 1, "R8", "external release", int'(pwr_en), 1);

      // R9 leaving the window, R10 ramp force
      run(DLY + 2, "R9");
      vv = 10'd445; run(DLY - 1, "R9");
      chk(pg == 1, "R9", "pg holds during qualification", int'(pg), 1);
      run(1, "R9");
      chk(pg == 0, "R9", "pg drops", int'(pg), 0);
      vv = 10'd400; run(DLY + 1, "R9");
      ramp = 1'b1; run(1, "R10");
      chk(pg == 0, "R10", "ramp forces pg low", int'(pg), 0);
      ramp = 1'b0;

      // random phase
      for (int r = 0; r < 400; r++) begin
         sp  = VW'(150 + $urandom_range(650));
         pct = 60 + int'($urandom_range(80));
         vv  = VW'(((int'(sp) * pct) / 100 > 1023) ? 1023 : (int'(sp) * pct) / 100);
         ii  = IW'($urandom_range(600));
         tt  = TW'(95 + $urandom_range(30));
         en  = ($urandom_range(99) < 85) ? pol : ~pol;
         if ($urandom_range(99) < 5) begin pol = ~pol; en = ~en; end
         ramp = ($urandom_range(99) < 10);
         okin = ($urandom_range(99) < 95);
         seg  = 1 + int'($urandom_range(11));
         run(seg, "R1-R10 random");
      end
      finish_run();
   end

endmodule